// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table held in word-addressed memory. A request carries the virtual address and the table base register. The walker reads the first-level entry and decodes its two type bits. Depending on that type, it either finishes with a direct block mapping (a 1MB section or a 16MB supersection), reports a fault, or follows a pointer to a coarse second-level table. In the last case it reads one more entry, which maps a 64KB large page or a 4KB small page, or reports a fault.

The result gives the physical address, a size class, the execute-never flag, a fault flag and the table level that faulted. It also returns the final descriptor word unmodified, so that the permission and attribute bits can be interpreted further along. The memory port allows one read in flight. The port pulses a request with an address, and the data comes back with a valid strobe one or more cycles later. A result stays on the outputs until it is acknowledged. New requests are taken only while the walker is idle.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `rsp_valid` and `mem_req` are 0.
- R2: An accepted request issues exactly one first-level read, as a single-cycle `mem_req` pulse. Its word address is table base bits [31:14], then virtual address bits [31:20], then two zero bits.
- R3: A first-level descriptor whose bits [1:0] are 00 or 11 ends the walk with `rsp_fault`=1, `rsp_flvl`=0 and `rsp_pa`=0, and no second read is issued.
- R4: A first-level descriptor of type 10 with bit 18 clear is a section. `rsp_size` is 0, `rsp_pa` is descriptor[31:20] followed by VA[19:0], and `rsp_xn` is descriptor bit 4.
- R5: A first-level descriptor of type 10 with bit 18 set is a supersection. `rsp_size` is 1, `rsp_pa` is descriptor[31:24] followed by VA[23:0], and `rsp_xn` is descriptor bit 4. The address does not depend on descriptor bits [23:20], so all 16 replicated copies give the same mapping.
- R6: A first-level descriptor of type 01 causes one second-level read. Its word address is descriptor[31:10], then VA[19:12], then two zero bits.
- R7: A second-level descriptor with bits [1:0] = 00 ends the walk with `rsp_fault`=1, `rsp_flvl`=1 and `rsp_pa`=0.
- R8: A second-level descriptor with bits [1:0] = 01 is a large page. `rsp_size` is 2, `rsp_pa` is descriptor[31:16] followed by VA[15:0], and `rsp_xn` is descriptor bit 15. The address does not depend on descriptor bits [15:12], so replicated copies agree.
- R9: A second-level descriptor with bit 1 set is a small page. `rsp_size` is 3, `rsp_pa` is descriptor[31:12] followed by VA[11:0], and `rsp_xn` is descriptor bit 0.
- R10: While `rsp_valid` is 1 and `rsp_ack` is 0, every result output holds its value, `req_ready` is 0, and `req_valid` has no effect (no memory read is issued). One cycle with `rsp_ack` returns the walker to idle.
- R11: `rsp_desc` returns the last descriptor read (first-level or second-level) unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 32 | Virtual address to translate |
| req_ttb | input | 32 | Table base register |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| mem_req | output | 1 | One-cycle read request pulse |
| mem_addr | output | 32 | Word address of the descriptor read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Result available |
| rsp_ack | input | 1 | Result consumed |
| rsp_pa | output | 32 | Physical address |
| rsp_size | output | 2 | 0 section, 1 supersection, 2 large page, 3 small page |
| rsp_xn | output | 1 | Execute-never flag |
| rsp_fault | output | 1 | Translation fault |
| rsp_flvl | output | 1 | Level that faulted: 0 first, 1 second |
| rsp_desc | output | 32 | Raw final descriptor |

## Verification
The bench builds the walker with its default field positions: 1MB sections, 16MB supersections, 64KB large pages, 4KB small pages, an 8-bit coarse index, and execute-never at bit 4 for blocks and bit 15 for large pages. With these values, random descriptor words reach every type code at both levels, and random latencies (including zero) on the memory port reach back-to-back second-level requests. Random bits in the replicated address fields confirm that the physical address draws those bits from the virtual address.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_L1   = 2'd1,
        ST_L2   = 2'd2,
        ST_DONE = 2'd3
    } walk_st_e;

    typedef enum logic [1:0] {
        SZ_SECTION = 2'd0,
        SZ_SUPER   = 2'd1,
        SZ_LARGE   = 2'd2,
        SZ_SMALL   = 2'd3
    } map_size_e;

    typedef enum logic [1:0] {
        L1K_FAULT = 2'd0,
        L1K_TABLE = 2'd1,
        L1K_BLOCK = 2'd2
    } l1_kind_e;

    typedef struct packed {
        walk_st_e  st;
        logic      issued;
        logic [31:0] va;
        logic [31:0] maddr;
        logic [31:0] pa;
        map_size_e size;
        logic      xn;
        logic      fault;
        logic      flvl;
        logic [31:0] desc;
    } walk_s;

    function automatic logic [31:0] low_mask(input int unsigned sh);
        return (32'd1 << sh) - 32'd1;
    endfunction

endpackage

// File: rtl/ptw_l1_decode.sv
`timescale 1ns/1ps
module ptw_l1_decode
    import ptw_pkg::*;
#(
    parameter int SECT_SHIFT  = 20,
    parameter int SUPER_SHIFT = 24,
    parameter int SUPER_BIT   = 18,
    parameter int BLK_XN_BIT  = 4,
    parameter int PAGE_SHIFT  = 12
) (
    input  logic [31:0] desc_i,
    input  logic [31:0] va_i,
    output l1_kind_e    kind_o,
    output logic [31:0] pa_o,
    output map_size_e   size_o,
    output logic        xn_o,
    output logic [31:0] next_addr_o
);
    localparam int L2_IDX_W      = SECT_SHIFT - PAGE_SHIFT;
    localparam int L2_BASE_SHIFT = L2_IDX_W + 2;
    localparam logic [31:0] SECT_MASK  = low_mask(SECT_SHIFT);
    localparam logic [31:0] SUPER_MASK = low_mask(SUPER_SHIFT);
    localparam logic [31:0] L2B_MASK   = low_mask(L2_BASE_SHIFT);
    localparam logic [31:0] IDX_MASK   = low_mask(L2_IDX_W);

    logic [31:0] l2_index;

    always_comb begin
        l2_index    = ((va_i >> PAGE_SHIFT) & IDX_MASK) << 2;
        next_addr_o = (desc_i & ~L2B_MASK) | l2_index;
        xn_o        = desc_i[BLK_XN_BIT];
        if (desc_i[SUPER_BIT]) begin
            size_o = SZ_SUPER;
            pa_o   = (desc_i & ~SUPER_MASK) | (va_i & SUPER_MASK);
        end else begin
            size_o = SZ_SECTION;
            pa_o   = (desc_i & ~SECT_MASK) | (va_i & SECT_MASK);
        end
        unique case (desc_i[1:0])
            2'b01:   kind_o = L1K_TABLE;
            2'b10:   kind_o = L1K_BLOCK;
            default: kind_o = L1K_FAULT;
        endcase
    end
endmodule

// File: rtl/ptw_l2_decode.sv
`timescale 1ns/1ps
module ptw_l2_decode
    import ptw_pkg::*;
#(
    parameter int LARGE_SHIFT  = 16,
    parameter int PAGE_SHIFT   = 12,
    parameter int LARGE_XN_BIT = 15
) (
    input  logic [31:0] desc_i,
    input  logic [31:0] va_i,
    output logic        fault_o,
    output logic [31:0] pa_o,
    output map_size_e   size_o,
    output logic        xn_o
);
    localparam logic [31:0] LARGE_MASK = low_mask(LARGE_SHIFT);
    localparam logic [31:0] SMALL_MASK = low_mask(PAGE_SHIFT);

    always_comb begin
        fault_o = 1'b0;
        if (desc_i[1]) begin
            size_o = SZ_SMALL;
            pa_o   = (desc_i & ~SMALL_MASK) | (va_i & SMALL_MASK);
            xn_o   = desc_i[0];
        end else begin
            size_o  = SZ_LARGE;
            pa_o    = (desc_i & ~LARGE_MASK) | (va_i & LARGE_MASK);
            xn_o    = desc_i[LARGE_XN_BIT];
            fault_o = ~desc_i[0];
        end
    end
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int SECT_SHIFT   = 20,
    parameter int SUPER_SHIFT  = 24,
    parameter int SUPER_BIT    = 18,
    parameter int BLK_XN_BIT   = 4,
    parameter int LARGE_SHIFT  = 16,
    parameter int LARGE_XN_BIT = 15,
    parameter int PAGE_SHIFT   = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_va,
    input  logic [31:0] req_ttb,
    output logic        req_ready,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        rsp_valid,
    input  logic        rsp_ack,
    output logic [31:0] rsp_pa,
    output logic [1:0]  rsp_size,
    output logic        rsp_xn,
    output logic        rsp_fault,
    output logic        rsp_flvl,
    output logic [31:0] rsp_desc
);
    localparam int L1_IDX_W  = 32 - SECT_SHIFT;
    localparam int TTB_SHIFT = L1_IDX_W + 2;
    localparam logic [31:0] TTB_MASK = low_mask(TTB_SHIFT);

    walk_s q, d;

    l1_kind_e    l1_kind;
    logic [31:0] l1_pa, l2_addr, l2_pa, l1_entry_addr;
    map_size_e   l1_size, l2_size;
    logic        l1_xn, l2_xn, l2_fault;

    ptw_l1_decode #(
        .SECT_SHIFT (SECT_SHIFT),
        .SUPER_SHIFT(SUPER_SHIFT),
        .SUPER_BIT  (SUPER_BIT),
        .BLK_XN_BIT (BLK_XN_BIT),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_l1 (
        .desc_i     (mem_rdata),
        .va_i       (q.va),
        .kind_o     (l1_kind),
        .pa_o       (l1_pa),
        .size_o     (l1_size),
        .xn_o       (l1_xn),
        .next_addr_o(l2_addr)
    );

    ptw_l2_decode #(
        .LARGE_SHIFT (LARGE_SHIFT),
        .PAGE_SHIFT  (PAGE_SHIFT),
        .LARGE_XN_BIT(LARGE_XN_BIT)
    ) u_l2 (
        .desc_i (mem_rdata),
        .va_i   (q.va),
        .fault_o(l2_fault),
        .pa_o   (l2_pa),
        .size_o (l2_size),
        .xn_o   (l2_xn)
    );

    assign l1_entry_addr = (req_ttb & ~TTB_MASK) | ((req_va >> SECT_SHIFT) << 2);

    always_comb begin
        d       = q;
        mem_req = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st     = ST_L1;
                    d.issued = 1'b0;
                    d.va     = req_va;
                    d.maddr  = l1_entry_addr;
                end
            end
            ST_L1: begin
                mem_req  = ~q.issued;
                d.issued = 1'b1;
                if (mem_rvalid) begin
                    d.desc = mem_rdata;
                    unique case (l1_kind)
                        L1K_TABLE: begin
                            d.st     = ST_L2;
                            d.issued = 1'b0;
                            d.maddr  = l2_addr;
                        end
                        L1K_BLOCK: begin
                            d.st    = ST_DONE;
                            d.pa    = l1_pa;
                            d.size  = l1_size;
                            d.xn    = l1_xn;
                            d.fault = 1'b0;
                            d.flvl  = 1'b0;
                        end
                        default: begin
                            d.st    = ST_DONE;
                            d.pa    = '0;
                            d.size  = SZ_SECTION;
                            d.xn    = 1'b0;
                            d.fault = 1'b1;
                            d.flvl  = 1'b0;
                        end
                    endcase
                end
            end
            ST_L2: begin
                mem_req  = ~q.issued;
                d.issued = 1'b1;
                if (mem_rvalid) begin
                    d.desc  = mem_rdata;
                    d.st    = ST_DONE;
                    d.flvl  = 1'b1;
                    d.fault = l2_fault;
                    if (l2_fault) begin
                        d.pa   = '0;
                        d.size = SZ_SECTION;
                        d.xn   = 1'b0;
                    end else begin
                        d.pa   = l2_pa;
                        d.size = l2_size;
                        d.xn   = l2_xn;
                    end
                end
            end
            default: begin
                if (rsp_ack) d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, size: SZ_SECTION, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = (q.st == ST_DONE);
    assign mem_addr  = q.maddr;
    assign rsp_pa    = q.pa;
    assign rsp_size  = q.size;
    assign rsp_xn    = q.xn;
    assign rsp_fault = q.fault;
    assign rsp_flvl  = q.flvl;
    assign rsp_desc  = q.desc;
endmodule

// File: rtl/ptw_walker_chk.sv
`timescale 1ns/1ps
module ptw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        mem_req,
    input logic        mem_rvalid,
    input logic        rsp_valid,
    input logic        rsp_ack,
    input logic [31:0] rsp_pa,
    input logic [1:0]  rsp_size,
    input logic        rsp_xn,
    input logic        rsp_fault,
    input logic        rsp_flvl,
    input logic [31:0] rsp_desc
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !rsp_valid));

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> !mem_req);

    assert_l1_fault_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && !rsp_flvl) |-> (rsp_pa == 32'd0 &&
            (rsp_desc[1:0] == 2'b00 || rsp_desc[1:0] == 2'b11)));

    assert_l2_fault_type_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && rsp_flvl) |-> (rsp_pa == 32'd0 && rsp_desc[1:0] == 2'b00));

    assert_small_xn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && rsp_size == 2'd3) |-> (rsp_xn == rsp_desc[0]));

    assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_desc) &&
            $stable(rsp_size) && $stable(rsp_xn) && $stable(rsp_fault) && $stable(rsp_flvl)));

    assert_busy_no_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!mem_req && !req_ready));
endmodule

bind ptw_walker ptw_walker_chk u_chk (.*);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0, req_ttb = '0;
    logic        req_ready, mem_req, mem_rvalid = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic        rsp_valid, rsp_ack = 1'b0;
    logic [31:0] rsp_pa, rsp_desc;
    logic [1:0]  rsp_size;
    logic        rsp_xn, rsp_fault, rsp_flvl;

    always #2 clk = ~clk;

    ptw_walker u_dut (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    logic [31:0] g_d1 = '0, g_d2 = '0;
    logic [31:0] rd_addr [4];
    int nrd = 0, lat = 0;
    bit pend = 1'b0;

    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (!rst_n) begin
            pend = 1'b0;
        end else begin
            if (mem_req) begin
                if (nrd < 4) rd_addr[nrd] = mem_addr;
                nrd  = nrd + 1;
                pend = 1'b1;
                lat  = int'($urandom % 4);
            end
            if (pend) begin
                if (lat == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = (nrd <= 1) ? g_d1 : g_d2;
                    pend       = 1'b0;
                end else begin
                    lat = lat - 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] va, ttb, d1, d2,
                         output logic [31:0] pa, a1, a2, desc,
                         output logic [1:0] sz, output logic xn, f, lv,
                         output int nr, output string tag);
        a1 = {ttb[31:14], va[31:20], 2'b00};
        a2 = '0; pa = '0; sz = 2'd0; xn = 1'b0; f = 1'b0; lv = 1'b0;
        nr = 1; desc = d1;
        case (d1[1:0])
            2'b10: begin
                xn = d1[4];
                if (d1[18]) begin pa = {d1[31:24], va[23:0]}; sz = 2'd1; tag = "R5"; end
                else        begin pa = {d1[31:20], va[19:0]}; sz = 2'd0; tag = "R4"; end
            end
            2'b01: begin
                a2 = {d1[31:10], va[19:12], 2'b00};
                nr = 2; desc = d2; lv = 1'b1;
                if (d2[1]) begin
                    pa = {d2[31:12], va[11:0]}; sz = 2'd3; xn = d2[0]; tag = "R9";
                end else if (d2[0]) begin
                    pa = {d2[31:16], va[15:0]}; sz = 2'd2; xn = d2[15]; tag = "R8";
                end else begin
                    f = 1'b1; tag = "R7";
                end
            end
            default: begin f = 1'b1; tag = "R3"; end
        endcase
    endtask

    task automatic txn(input logic [31:0] va, ttb, d1, d2, input int hold);
        logic [31:0] e_pa, e_a1, e_a2, e_desc;
        logic [1:0]  e_sz;
        logic        e_xn, e_f, e_lv;
        int          e_nr, w;
        string       tg;
        model(va, ttb, d1, d2, e_pa, e_a1, e_a2, e_desc, e_sz, e_xn, e_f, e_lv, e_nr, tg);
        @(negedge clk);
        g_d1 = d1; g_d2 = d2; nrd = 0;
        req_valid = 1'b1; req_va = va; req_ttb = ttb;
        @(negedge clk);
        req_valid = 1'b0;
        w = 0;
        while (!rsp_valid && w < 50) begin @(negedge clk); w++; end
        chk({tg, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
        chk({tg, " pa"}, rsp_pa, e_pa);
        chk({tg, " fault"}, {31'd0, rsp_fault}, {31'd0, e_f});
        if (e_f) chk({tg, " fault level"}, {31'd0, rsp_flvl}, {31'd0, e_lv});
        else begin
            chk({tg, " size"}, {30'd0, rsp_size}, {30'd0, e_sz});
            chk({tg, " xn"}, {31'd0, rsp_xn}, {31'd0, e_xn});
        end
        chk("R11 raw descriptor", rsp_desc, e_desc);
        chk({tg, " read count (R3/R6)"}, nrd, e_nr);
        chk("R2 level-one address", rd_addr[0], e_a1);
        if (e_nr == 2) chk("R6 level-two address", rd_addr[1], e_a2);
        for (int i = 0; i < hold; i++) begin
            req_valid = 1'b1; req_va = ~va;
            @(negedge clk);
            chk("R10 held valid", {31'd0, rsp_valid}, 32'd1);
            chk("R10 held pa", rsp_pa, e_pa);
        end
        req_valid = 1'b0;
        chk("R10 request ignored while busy", nrd, e_nr);
        rsp_ack = 1'b1;
        @(negedge clk);
        rsp_ack = 1'b0;
        chk("R10 released", {31'd0, rsp_valid}, 32'd0);
        chk("R10 ready again", {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] va, d1;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", {31'd0, req_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", {31'd0, req_ready}, 32'd1);
        chk("R1 no result", {31'd0, rsp_valid}, 32'd0);
        chk("R1 no read", {31'd0, mem_req}, 32'd0);

        // R3: both fault codes at level one
        txn(32'h1234_5678, 32'hABCD_4000, 32'hFFFF_FFFC, 32'h0, 1);
        txn(32'h8765_4321, 32'h0000_C000, 32'h5555_5557, 32'h0, 0);
        // R4: section with xn set
        txn(32'hDEAD_BEEF, 32'h1000_0000, 32'hFFF0_0012, 32'h0, 2);
        // R5: supersection, two replicated slots
        d1 = 32'hA5F4_0C02;
        txn(32'h3C1A_2B3C, 32'h2000_0000, d1, 32'h0, 0);
        txn(32'h3CFA_2B3C, 32'h2000_0000, d1, 32'h0, 0);
        // R8: large page with xn at bit 15, replicated slots
        txn(32'h0012_3456, 32'h4000_0000, 32'h9999_9801, 32'hBEEF_F005, 1);
        txn(32'h0012_0456, 32'h4000_0000, 32'h9999_9801, 32'hBEEF_F005, 0);
        // R9: small pages, xn 1 and 0
        txn(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FC01, 32'h1234_5003, 0);
        txn(32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 32'h1234_5002, 0);
        // R7: second-level fault
        txn(32'h7777_7777, 32'h8000_0000, 32'h0000_0401, 32'hFFFF_FFFC, 3);

        for (int i = 0; i < 600; i++) begin
            va = $urandom;
            txn(va, $urandom, $urandom, $urandom, int'($urandom % 3));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule